// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor core. Each source has a pending line, an enable bit and a one-bit level selector (0 = low level, 1 = high level). A global enable gates all sources. On every clock the enabled pending lines are registered. The registered set is then decoded to find one winner. That winner is offered to the CPU as a vectored call, and the call is made only at an instruction boundary.

The controller tracks service with a two-entry in-service record, one flag per level. A high-level request may interrupt a low-level routine. Nothing interrupts a high-level routine, and a request never interrupts a routine of its own level. When the CPU reports that a return has completed, the controller clears the most recently entered level. It then lets exactly one more instruction finish before it issues the next call. The CPU datapath, the vector table and register decoding sit outside the block.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After a synchronous reset, `call_req`, `insvc_hi` and `insvc_lo` are 0.
- R2: Pending lines are registered on every clock edge. With `cpu_boundary` held high and no routine in service, `call_req` is 0 after the first edge following a request. It is 1 after the second edge, with `call_idx` equal to the source index and `call_hi` equal to that source's level bit.
- R3: When requests of both levels are pending together, the high-level request is called first.
- R4: Among pending requests of the same level, the lowest source index wins.
- R5: While `call_req` is 1 and `cpu_ack` is 0, `call_req`, `call_idx` and `call_hi` stay unchanged, even if a more urgent request arrives.
- R6: An edge with `cpu_ack` high while `call_req` is 1 clears `call_req` and sets the in-service flag of the called level (`insvc_hi` if `call_hi` is 1, else `insvc_lo`).
- R7: A high-level request is called while `insvc_lo` is 1 and `insvc_hi` is 0.
- R8: No call is issued while `insvc_hi` is 1. A low-level request is not called while `insvc_lo` is 1.
- R9: An edge with `cpu_reti` high clears `insvc_hi` if it is set; otherwise it clears `insvc_lo`.
- R10: No call is issued on the edge where `cpu_reti` is high. With `cpu_boundary` high, an eligible request is called on the next edge, so exactly one instruction runs after the return.
- R11: A call is issued only on an edge where `cpu_boundary` is 1.
- R12: A source whose enable bit is 0 is never called. When `glb_en` is 0, no source is called.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NSRC | Pending request lines, one per source |
| irq_en | input | NSRC | Per-source enable bits |
| irq_lvl | input | NSRC | Per-source level selector, 1 = high |
| glb_en | input | 1 | Global interrupt enable |
| cpu_boundary | input | 1 | High on a cycle that ends an instruction |
| cpu_ack | input | 1 | The CPU accepts the offered call |
| cpu_reti | input | 1 | A return-from-interrupt completes on this boundary |
| call_req | output | 1 | Vectored call requested |
| call_idx | output | IDX_W | Index of the source being called |
| call_hi | output | 1 | Level of the call, 1 = high |
| insvc_hi | output | 1 | A high-level routine is in service |
| insvc_lo | output | 1 | A low-level routine is in service |

## Verification
Embedded assertions check, on every cycle:
- the call outputs hold steady until the CPU accepts the call;
- no call starts while a high-level routine is active;
- no call starts right after a return edge or away from a boundary;
- a low-level call is never chosen over a pending high-level one;
- the in-service flags are set on acceptance and cleared on return as required.

The bench scenarios show what a property cannot show alone:
- the two-edge latency;
- the index order within a level;
- enable masking;
- the full nesting sequence, where low is pre-empted by high, then returns unwind in order and each return is followed by a one-instruction gap.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } lvl_e;
endpackage

// File: rtl/irq_sample.sv
// Registers the enabled pending lines and splits them by level.
module irq_sample #(
  parameter int NSRC = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NSRC-1:0]            req,
  input  logic [NSRC-1:0]            en,
  input  logic [NSRC-1:0]            lvl,
  input  logic                       glb_en,
  output logic [1:0][NSRC-1:0]       pend
);
  logic [NSRC-1:0] live;

  assign live = req & en & {NSRC{glb_en}};

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else begin
      pend[0] <= live & ~lvl;
      pend[1] <= live & lvl;
    end
  end
endmodule

// File: rtl/irq_pick.sv
// Fixed-order picker: the lowest set index wins.
module irq_pick #(
  parameter int NSRC  = 8,
  parameter int IDX_W = 3
) (
  input  logic [NSRC-1:0]  vec,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (vec[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_insvc.sv
// Two-entry in-service record: set on call acceptance, unwound on return.
module irq_insvc (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic take_hi,
  input  logic ret,
  output logic act_hi,
  output logic act_lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      act_hi <= 1'b0;
      act_lo <= 1'b0;
    end else if (take) begin
      if (take_hi) act_hi <= 1'b1;
      else         act_lo <= 1'b1;
    end else if (ret) begin
      if (act_hi) act_hi <= 1'b0;
      else        act_lo <= 1'b0;
    end
  end

  // R6
  take_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (take_hi ? act_hi : act_lo));

  // R9
  ret_pops_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (ret && !take && act_hi) |=> (!act_hi && $stable(act_lo)));

  // R9
  ret_pops_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (ret && !take && !act_hi) |=> (!act_lo && !act_hi));
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int NSRC  = 8,
  parameter int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  irq_req,
  input  logic [NSRC-1:0]  irq_en,
  input  logic [NSRC-1:0]  irq_lvl,
  input  logic             glb_en,
  input  logic             cpu_boundary,
  input  logic             cpu_ack,
  input  logic             cpu_reti,
  output logic             call_req,
  output logic [IDX_W-1:0] call_idx,
  output logic             call_hi,
  output logic             insvc_hi,
  output logic             insvc_lo
);
  import irq_nest_pkg::*;

  localparam int NLVL = 2;

  logic [NLVL-1:0][NSRC-1:0]  pend;
  logic [NLVL-1:0]            lv_hit;
  logic [NLVL-1:0][IDX_W-1:0] lv_idx;
  logic                       hi_ok, lo_ok, win_ok, issue, take;
  logic [IDX_W-1:0]           win_idx;
  lvl_e                       win_lvl, call_lvl;

  irq_sample #(.NSRC(NSRC)) u_sample (
    .clk    (clk),
    .rst    (rst),
    .req    (irq_req),
    .en     (irq_en),
    .lvl    (irq_lvl),
    .glb_en (glb_en),
    .pend   (pend)
  );

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    irq_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
      .vec (pend[g]),
      .hit (lv_hit[g]),
      .idx (lv_idx[g])
    );
  end

  // Eligibility: high blocked only by high; low blocked by either level
  // and by any pending high request.
  assign hi_ok   = lv_hit[1] && !insvc_hi;
  assign lo_ok   = lv_hit[0] && !lv_hit[1] && !insvc_hi && !insvc_lo;
  assign win_ok  = hi_ok || lo_ok;
  assign win_idx = hi_ok ? lv_idx[1] : lv_idx[0];
  assign win_lvl = hi_ok ? LVL_HI : LVL_LO;

  // Calls start only at a boundary that is not the end of a return.
  assign issue = cpu_boundary && !cpu_reti && !call_req && win_ok;
  assign take  = cpu_ack && call_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      call_req <= 1'b0;
      call_idx <= '0;
      call_lvl <= LVL_LO;
    end else if (issue) begin
      call_req <= 1'b1;
      call_idx <= win_idx;
      call_lvl <= win_lvl;
    end else if (take) begin
      call_req <= 1'b0;
    end
  end

  assign call_hi = (call_lvl == LVL_HI);

  irq_insvc u_insvc (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .take_hi (call_hi),
    .ret     (cpu_reti),
    .act_hi  (insvc_hi),
    .act_lo  (insvc_lo)
  );

  // R5
  call_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (call_req && !cpu_ack) |=> (call_req && $stable(call_idx) && $stable(call_hi)));

  // R8
  hi_no_preempt_chk: assert property (@(posedge clk) disable iff (rst)
    insvc_hi |=> !$rose(call_req));

  // R10
  ret_gap_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_reti |=> !$rose(call_req));

  // R11
  boundary_only_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_boundary |=> !$rose(call_req));

  // R3
  hi_first_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(call_req) && !call_hi) |-> ($past(pend[1]) == '0));
endmodule

// File: tb/irq_nest_ctrl_tb.sv
module irq_nest_ctrl_tb;
  localparam int NSRC = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req = '0, en = 8'hFF, prio = '0;
  logic       glb_en = 1'b1, bnd = 1'b1, ack = 1'b0, reti = 1'b0;
  logic       call_req, call_hi, insvc_hi, insvc_lo;
  logic [2:0] call_idx;
  int         nchk = 0, nerr = 0;
  bit         done = 1'b0;
  logic [27:0] v;

  always #2 clk = ~clk;

  irq_nest_ctrl #(.NSRC(NSRC)) u_dut (
    .clk(clk), .rst(rst), .irq_req(req), .irq_en(en), .irq_lvl(prio),
    .glb_en(glb_en), .cpu_boundary(bnd), .cpu_ack(ack), .cpu_reti(reti),
    .call_req(call_req), .call_idx(call_idx), .call_hi(call_hi),
    .insvc_hi(insvc_hi), .insvc_lo(insvc_lo)
  );

  // {req, level bits, enables, expected index, expected level}
  localparam logic [27:0] VEC [0:5] = '{
    {8'h01, 8'h00, 8'hFF, 3'd0, 1'b0},  // R2 single low source
    {8'hA0, 8'h00, 8'hFF, 3'd5, 1'b0},  // R4 lowest index among low
    {8'h81, 8'h80, 8'hFF, 3'd7, 1'b1},  // R3 high beats lower index low
    {8'hC4, 8'hC0, 8'hFF, 3'd6, 1'b1},  // R4 lowest index among high
    {8'h0F, 8'h00, 8'h0C, 3'd2, 1'b0},  // R12 masked sources skipped
    {8'h30, 8'h10, 8'hFF, 3'd4, 1'b1}   // R3 high wins mixed pair
  };

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic accept;
    ack = 1'b1; tick; ack = 1'b0;
  endtask

  task automatic ret_once;
    reti = 1'b1; tick; reti = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    tick; tick;
    chk("R1 call_req", call_req, 0);
    chk("R1 insvc_hi", insvc_hi, 0);
    chk("R1 insvc_lo", insvc_lo, 0);
    rst = 1'b0;

    for (int k = 0; k < 6; k++) begin
      v = VEC[k];
      req = v[27:20]; prio = v[19:12]; en = v[11:4];
      tick;
      chk("R2 detect cycle", call_req, 0);
      tick;
      chk("R2 call_req", call_req, 1);
      chk("R3/R4 call_idx", call_idx, int'(v[3:1]));
      chk("R3 call_hi", call_hi, int'(v[0]));
      req = '0;
      accept;
      chk("R6 call cleared", call_req, 0);
      chk("R6 level flag", v[0] ? insvc_hi : insvc_lo, 1);
      ret_once;
      chk("R9 hi cleared", insvc_hi, 0);
      chk("R9 lo cleared", insvc_lo, 0);
    end

    en = 8'hFF; prio = 8'h0C;
    req = 8'h02; tick; tick;
    chk("R2 low call", call_req, 1);
    chk("R2 low idx", call_idx, 1);
    req = '0; accept;
    chk("R6 insvc_lo", insvc_lo, 1);

    req = 8'h40; tick; tick; tick;
    chk("R8 low blocks low", call_req, 0);

    req = 8'h48; tick; tick;
    chk("R7 preempt call", call_req, 1);
    chk("R7 preempt idx", call_idx, 3);
    chk("R7 preempt level", call_hi, 1);
    req = 8'h40; accept;
    chk("R6 insvc_hi", insvc_hi, 1);
    chk("R6 insvc_lo kept", insvc_lo, 1);

    req = 8'h44; tick; tick; tick;
    chk("R8 high blocks high", call_req, 0);

    ret_once;
    chk("R9 pop high", insvc_hi, 0);
    chk("R9 low stays", insvc_lo, 1);
    chk("R10 no call on return", call_req, 0);
    tick;
    chk("R10 call after gap", call_req, 1);
    chk("R10 gap idx", call_idx, 2);
    req = 8'h40; accept;
    ret_once;
    chk("R9 pop high again", insvc_hi, 0);
    tick;
    chk("R8 low still blocked", call_req, 0);
    ret_once;
    chk("R9 pop low", insvc_lo, 0);
    chk("R10 no call on return", call_req, 0);
    tick;
    chk("R10 low call after gap", call_req, 1);
    chk("R10 low idx", call_idx, 6);
    chk("R10 low level", call_hi, 0);
    req = '0; accept; ret_once; tick;

    bnd = 1'b0; req = 8'h01; tick; tick; tick; tick;
    chk("R11 no boundary", call_req, 0);
    bnd = 1'b1; tick;
    chk("R11 boundary call", call_req, 1);
    chk("R11 idx", call_idx, 0);

    prio = 8'h8C; req = 8'h81; tick; tick; tick;
    chk("R5 held req", call_req, 1);
    chk("R5 held idx", call_idx, 0);
    chk("R5 held level", call_hi, 0);
    req = '0; accept; ret_once; tick;

    glb_en = 1'b0; req = 8'hFF; tick; tick; tick;
    chk("R12 global off", call_req, 0);
    glb_en = 1'b1; tick; tick;
    chk("R12 global on", call_req, 1);
    chk("R12 idx", call_idx, 2);
    chk("R12 level", call_hi, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule